// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Memory

This block is a small synchronous store in which every address selects one 8-bit byte. It is reached through one port that moves either a single byte or a 4-byte word. Each request carries a byte address, a size, a direction, write data and a byte-order select. A word at byte address X covers bytes X through X+3, so words start at multiples of four. The order select decides whether the most significant byte of the word sits at X (big-endian) or at X+3 (little-endian). It is sampled with each request, so one stored word can be read back in either order.

An address register and a data register sit in front of the storage. On every accepted request the address register captures the request address. The data register captures one of two values. For a read it takes the value fetched from storage. For a write it takes the value written. A read therefore shows its result in the data register on the clock edge that accepts the request.

A word request whose address is not a multiple of four is refused and raises a flag. An address at or beyond the configured depth is treated as unbacked.

Top module: `bem_byte_memory`

## Requirements
- R1: After reset the address register, the data register and the misalignment flag are zero, and every stored byte reads back as zero.
- R2: On each edge where `req_valid` is high, `held_addr` takes `req_addr`; while `req_valid` is low it keeps its value whatever the other request inputs do.
- R3: A read accepted on a clock edge shows its data on `held_data` after that same edge, including a read that directly follows a write to the same word; with `req_valid` low, `held_data` and `misaligned` hold.
- R4: A word write with `req_big`=1 puts bits 31:24 at byte address X, 23:16 at X+1, 15:8 at X+2 and 7:0 at X+3.
- R5: A word write with `req_big`=0 puts bits 7:0 at byte address X, 15:8 at X+1, 23:16 at X+2 and 31:24 at X+3.
- R6: A word read assembles the four bytes using the order select of the read itself, so bytes written in one order and read in the other come back byte-reversed.
- R7: A byte write (`req_word`=0) stores `req_wdata[7:0]` at the addressed byte only; all other bytes, including the rest of its word, are unchanged.
- R8: A byte read returns the addressed byte in bits 7:0 with bits 31:8 zero, for either order select.
- R9: A word request with `req_addr[1:0]` not 00 sets `misaligned`, changes no stored byte and leaves `held_data` unchanged. The next request that is not a misaligned word clears the flag.
- R10: Addresses at or above `DEPTH` hold no storage: writes there change nothing, and reads there return zero.
- R11: A write loads `held_data` with the value written: all of `req_wdata` for a word write, `req_wdata[7:0]` zero-extended for a byte write, in range or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 4-byte word, 0 = single byte |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian word mapping |
| req_addr | input | $clog2(DEPTH) | Byte address |
| req_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| held_addr | output | $clog2(DEPTH) | Address register, address of the last accepted request |
| held_data | output | 32 | Data register, data of the last accepted read or write |
| misaligned | output | 1 | Last accepted request was a misaligned word access |

## Verification
The bench builds the memory with `DEPTH` = 40. This depth is a multiple of four but not a power of two. The 6-bit address can therefore name bytes 40 to 63, which have no storage behind them. This brings the unbacked-address rules within reach of ordinary stimulus. It also exercises the last real word, at 36 to 39, right next to that boundary. Both byte orders are written and read back crosswise, and a read is issued directly after a write to the same word.

// File: rtl/bem_pkg.sv
package bem_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef logic [BYTE_W-1:0]             byte_t;
    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [LANES-1:0][BYTE_W-1:0]  lanes_t;
    typedef logic [LANES-1:0]              lane_mask_t;
endpackage

// File: rtl/bem_lane_map.sv
// Maps a 32-bit word onto four byte lanes (lane j = byte address offset j)
// and back, in big- or little-endian order.
module bem_lane_map
    import bem_pkg::*;
(
    input  logic   big_i,
    input  word_t  word_i,
    output lanes_t lanes_o,
    input  lanes_t lanes_i,
    output word_t  word_o
);
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam int MIRROR = LANES - 1 - j;
            // big-endian: lowest offset carries the most significant byte
            assign lanes_o[j] = big_i ? word_i[MIRROR*BYTE_W +: BYTE_W]
                                      : word_i[j*BYTE_W +: BYTE_W];
            assign word_o[j*BYTE_W +: BYTE_W] = big_i ? lanes_i[MIRROR]
                                                      : lanes_i[j];
        end
    endgenerate
endmodule

// File: rtl/bem_byte_array.sv
// Byte storage organised as four lanes of NWORDS bytes each, with per-lane
// write enables and a combinational read of one word index.
module bem_byte_array
    import bem_pkg::*;
#(
    parameter  int NWORDS = 16,
    localparam int IDXW   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] wr_idx,
    input  lane_mask_t      lane_we,
    input  lanes_t          wr_lanes,
    input  logic [IDXW-1:0] rd_idx,
    output lanes_t          rd_lanes
);
    localparam logic [IDXW:0] NWORDS_L = (IDXW+1)'(NWORDS);

    logic wr_ok;
    logic rd_ok;

    assign wr_ok = ({1'b0, wr_idx} < NWORDS_L);
    assign rd_ok = ({1'b0, rd_idx} < NWORDS_L);

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            byte_t mem_d [NWORDS];
            byte_t mem_q [NWORDS];

            always_comb begin
                mem_d = mem_q;
                if (lane_we[j] && wr_ok) begin
                    mem_d[wr_idx] = wr_lanes[j];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < NWORDS; w++) begin
                        mem_q[w] <= '0;
                    end
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign rd_lanes[j] = rd_ok ? mem_q[rd_idx] : '0;
        end
    endgenerate

    // a write touches no lane, exactly one lane, or the whole word
    AST_LANE_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_we) <= 1) || (lane_we == '1)); // R7
endmodule

// File: rtl/bem_byte_memory.sv
// Byte-addressed memory with a word port, selectable byte order, an address
// register and a data register in front of the storage.
module bem_byte_memory
    import bem_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_big,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic [AW-1:0] held_addr,
    output logic [31:0]   held_data,
    output logic          misaligned
);
    localparam int            NWORDS  = DEPTH / LANES;
    localparam int            IDX_W   = AW - 2;
    localparam logic [AW:0]   DEPTH_L = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] addr;
        word_t         data;
        logic          misal;
    } regs_t;

    regs_t            st_d;
    regs_t            st_q;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lane;
    logic             in_range;
    logic             unaligned;
    lane_mask_t       lane_we;
    lanes_t           wr_lanes;
    lanes_t           map_lanes;
    lanes_t           rd_lanes;
    word_t            rd_word;

    assign idx       = req_addr[AW-1:2];
    assign lane      = req_addr[1:0];
    assign in_range  = ({1'b0, req_addr} < DEPTH_L);
    assign unaligned = req_word && (lane != 2'b00);

    bem_lane_map u_map (
        .big_i   (req_big),
        .word_i  (req_wdata),
        .lanes_o (map_lanes),
        .lanes_i (rd_lanes),
        .word_o  (rd_word)
    );

    bem_byte_array #(
        .NWORDS (NWORDS)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_idx   (idx),
        .lane_we  (lane_we),
        .wr_lanes (wr_lanes),
        .rd_idx   (idx),
        .rd_lanes (rd_lanes)
    );

    always_comb begin
        st_d     = st_q;
        lane_we  = '0;
        wr_lanes = req_word ? map_lanes : {LANES{req_wdata[BYTE_W-1:0]}};
        if (req_valid) begin
            st_d.addr  = req_addr;
            st_d.misal = unaligned;
            if (!unaligned) begin
                if (req_write) begin
                    if (in_range) begin
                        lane_we = req_word ? '1 : lane_mask_t'(4'b0001 << lane);
                    end
                    st_d.data = req_word ? req_wdata
                                         : {{(WORD_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
                end else if (!in_range) begin
                    st_d.data = '0;
                end else begin
                    st_d.data = req_word ? rd_word
                                         : {{(WORD_W-BYTE_W){1'b0}}, rd_lanes[lane]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_addr  = st_q.addr;
    assign held_data  = st_q.data;
    assign misaligned = st_q.misal;

    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> held_addr == $past(req_addr)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(held_addr)); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(held_data) && $stable(misaligned)); // R3
    AST_MISALIGN_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_word && (req_addr[1:0] != 2'b00)
        |=> misaligned && $stable(held_data)); // R9
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_word |=> held_data[31:8] == '0); // R8
    AST_WORD_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_word && (req_addr[1:0] == 2'b00)
        |=> held_data == $past(req_wdata)); // R11
    AST_UNBACKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && ({1'b0, req_addr} >= DEPTH_L)
        && !(req_word && (req_addr[1:0] != 2'b00))
        |=> held_data == '0); // R10
endmodule

// File: tb/test_bem_byte_memory.sv
`timescale 1ns/1ps
module test_bem_byte_memory;
    localparam int TB_DEPTH = 40;
    localparam int TB_AW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_word = 1'b0;
    logic             req_big = 1'b0;
    logic [TB_AW-1:0] req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic [TB_AW-1:0] held_addr;
    logic [31:0]      held_data;
    logic             misaligned;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    bem_byte_memory #(.DEPTH(TB_DEPTH)) i_bem_byte_memory (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_big    (req_big),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .held_addr  (held_addr),
        .held_data  (held_data),
        .misaligned (misaligned)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one request, accepted at the next rising edge; returns at the following falling edge
    task automatic access(input logic wr, input logic wd, input logic big,
                          input logic [TB_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_big = big;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 addr after reset", 32'(held_addr), 32'h0);
        check("R1 data after reset", held_data, 32'h0);
        check("R1 flag after reset", 32'(misaligned), 32'h0);
        access(1'b0, 1'b1, 1'b1, 6'd0, '0);
        check("R1 word 0 cleared", held_data, 32'h0);
        access(1'b0, 1'b1, 1'b0, 6'd36, '0);
        check("R1 word 36 cleared", held_data, 32'h0);
    endtask

    task automatic t_big_order;
        access(1'b1, 1'b1, 1'b1, 6'd4, 32'h11223344);
        access(1'b0, 1'b0, 1'b1, 6'd4, '0);
        check("R4 byte 4 is MSB", held_data, 32'h11);
        access(1'b0, 1'b0, 1'b0, 6'd5, '0);
        check("R4 byte 5", held_data, 32'h22);
        access(1'b0, 1'b0, 1'b1, 6'd6, '0);
        check("R4 byte 6", held_data, 32'h33);
        access(1'b0, 1'b0, 1'b0, 6'd7, '0);
        check("R4 R8 byte 7 is LSB zero-ext", held_data, 32'h44);
        access(1'b0, 1'b1, 1'b1, 6'd4, '0);
        check("R6 big read of big word", held_data, 32'h11223344);
        access(1'b0, 1'b1, 1'b0, 6'd4, '0);
        check("R6 little read of big word", held_data, 32'h44332211);
    endtask

    task automatic t_little_order;
        access(1'b1, 1'b1, 1'b0, 6'd8, 32'hA1B2C3D4);
        access(1'b0, 1'b0, 1'b0, 6'd8, '0);
        check("R5 R8 byte 8 is LSB", held_data, 32'hD4);
        access(1'b0, 1'b0, 1'b1, 6'd11, '0);
        check("R5 byte 11 is MSB", held_data, 32'hA1);
        access(1'b0, 1'b1, 1'b1, 6'd8, '0);
        check("R6 big read of little word", held_data, 32'hD4C3B2A1);
        access(1'b0, 1'b1, 1'b1, 6'd4, '0);
        check("R7 neighbour word intact", held_data, 32'h11223344);
    endtask

    task automatic t_byte_write;
        access(1'b1, 1'b0, 1'b1, 6'd6, 32'hFFFFFF5A);
        check("R11 byte write data reg", held_data, 32'h0000005A);
        access(1'b0, 1'b1, 1'b1, 6'd4, '0);
        check("R7 only byte 6 changed", held_data, 32'h11225A44);
        access(1'b0, 1'b0, 1'b0, 6'd9, '0);
        check("R7 other word intact", held_data, 32'hC3);
    endtask

    task automatic t_hold;
        @(negedge clk);
        req_addr = 6'd33; req_wdata = 32'hFFFFFFFF; req_write = 1'b1; req_word = 1'b1;
        repeat (3) @(negedge clk);
        req_write = 1'b0; req_word = 1'b0;
        check("R2 addr held while idle", 32'(held_addr), 32'd9);
        check("R3 data held while idle", held_data, 32'hC3);
        access(1'b0, 1'b0, 1'b0, 6'd33, '0);
        check("R2 idle write ignored", held_data, 32'h0);
        check("R2 addr captured", 32'(held_addr), 32'd33);
    endtask

    task automatic t_misalign;
        access(1'b0, 1'b1, 1'b1, 6'd4, '0);
        access(1'b1, 1'b1, 1'b1, 6'd13, 32'hFFFFFFFF);
        check("R9 flag on misaligned write", 32'(misaligned), 32'h1);
        check("R9 data reg unchanged", held_data, 32'h11225A44);
        check("R2 addr of refused access", 32'(held_addr), 32'd13);
        access(1'b0, 1'b1, 1'b0, 6'd10, '0);
        check("R9 flag on misaligned read", 32'(misaligned), 32'h1);
        check("R9 data reg unchanged on read", held_data, 32'h11225A44);
        access(1'b0, 1'b0, 1'b0, 6'd13, '0);
        check("R9 flag cleared", 32'(misaligned), 32'h0);
        check("R9 no store at 13", held_data, 32'h0);
        access(1'b0, 1'b1, 1'b0, 6'd12, '0);
        check("R9 word 12 untouched", held_data, 32'h0);
    endtask

    task automatic t_unbacked;
        access(1'b1, 1'b1, 1'b1, 6'd36, 32'hCAFEF00D);
        access(1'b0, 1'b0, 1'b1, 6'd39, '0);
        check("R4 last byte of array", held_data, 32'h0D);
        access(1'b1, 1'b1, 1'b0, 6'd40, 32'hDEADBEEF);
        check("R11 unbacked write data reg", held_data, 32'hDEADBEEF);
        access(1'b0, 1'b1, 1'b0, 6'd40, '0);
        check("R10 unbacked word reads zero", held_data, 32'h0);
        access(1'b1, 1'b0, 1'b0, 6'd45, 32'h77);
        access(1'b0, 1'b0, 1'b0, 6'd45, '0);
        check("R10 unbacked byte reads zero", held_data, 32'h0);
        access(1'b0, 1'b1, 1'b1, 6'd36, '0);
        check("R10 last word unharmed", held_data, 32'hCAFEF00D);
        access(1'b0, 1'b1, 1'b1, 6'd0, '0);
        check("R10 no wrap into word 0", held_data, 32'h0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_big = 1'b0;
        req_addr = 6'd16; req_wdata = 32'h01020304;
        @(negedge clk);
        req_write = 1'b0; req_big = 1'b1; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 read right after write", held_data, 32'h04030201);
        check("R2 addr of second access", 32'(held_addr), 32'd16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_big_order();
        t_little_order();
        t_byte_write();
        t_hold();
        t_misalign();
        t_unbacked();
        t_back_to_back();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule